// File: doc/BRIEF.md
# Multi-Cycle Double-Width Left Shifter

This block shifts a narrow operand left by a variable distance, one bit position per clock, into a product twice as wide. The product is delivered as a low half and a high half, both the width of the operand. The high half collects the bits that leave the top of the low half. The caller presents an operation code, two operands and a one-cycle start strobe while the unit is idle. It then waits for the ready flag, which rises only once the last position has been shifted. A shift by zero returns at once.

A second operation moves the operand pair right by a single position in one clock. In that operation the second operand acts as the upper half of the pair. Any other operation code clears the low half and leaves ready low. The error flag is provided for the caller's use and stays low for every supported operation.

Top module: `seq_shift_unit`

## Requirements
- R1: While the active-low asynchronous reset is applied, both result halves, the ready flag and the error flag are 0.
- R2: With start high while idle and operation code 3'b001, the unit captures operand A and takes operand B as an unsigned count. When ready rises, {res_hi, res_lo} equals the 8-bit value {4'b0, A} shifted left by B, keeping the low 8 bits.
- R3: A left shift by a count B > 0 performs one position per clock. Ready is low on the clock that captures the operands and stays low until it rises exactly B clocks later.
- R4: While a left shift is in progress, start, the operation code and the operands are ignored. The final result depends only on the captured values.
- R5: A left shift by zero sets res_lo = A and res_hi = 0, with ready high on the capturing clock.
- R6: A left shift by any count from 8 to 15 leaves both halves at zero.
- R7: With start high while idle and code 3'b010, on that clock res_lo becomes {B[0], A[3:1]}, res_hi becomes {1'b0, B[3:1]}, and ready goes high.
- R8: With start high while idle and any other code, on that clock res_lo is cleared, ready and error go low, and res_hi keeps its value.
- R9: The error flag stays low throughout every supported operation.
- R10: While idle with start low, all outputs hold their values regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| clk | input | 1 | Clock |
| opnd_a | input | 4 | Operand to shift |
| opnd_b | input | 4 | Shift count (left) or upper half of the pair (right) |
| op_code | input | 3 | Operation select |
| start | input | 1 | Dispatch strobe, sampled while idle |
| res_lo | output | 4 | Low half of the product |
| res_hi | output | 4 | High half of the product |
| ready | output | 1 | Result valid |
| err | output | 1 | Error flag |

## Verification
The hardest situation to produce is a new dispatch that arrives while a long shift is still running. The bench starts a left shift by 11 and, on the following clocks, holds start high with a right-shift code and different operands. It then checks that the result matches the captured operand and that ready rises after exactly 11 clocks. It also confirms that the high half is kept across an unsupported code by first loading it with a nonzero value through a right shift.

// File: rtl/seq_shift_unit.sv
module seq_shift_unit #(
  parameter int DW = 4,
  parameter int OPW = 3,
  parameter logic [OPW-1:0] OP_SHL = 3'b001,
  parameter logic [OPW-1:0] OP_SHR = 3'b010
) (
  input  logic          rst_n,
  input  logic          clk,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [OPW-1:0] op_code,
  input  logic          start,
  output logic [DW-1:0] res_lo,
  output logic [DW-1:0] res_hi,
  output logic          ready,
  output logic          err
);
  localparam int CW = DW;

  logic [DW-1:0] lo_q, hi_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, rdy_q, err_q;

  assign res_lo = lo_q;
  assign res_hi = hi_q;
  assign ready  = rdy_q;
  assign err    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (busy_q) begin
      hi_q  <= {hi_q[DW-2:0], lo_q[DW-1]};
      lo_q  <= {lo_q[DW-2:0], 1'b0};
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b1;
      end
    end else if (start) begin
      err_q <= 1'b0;
      case (op_code)
        OP_SHL: begin
          lo_q  <= opnd_a;
          hi_q  <= '0;
          cnt_q <= opnd_b;
          if (opnd_b == '0) begin
            rdy_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            rdy_q  <= 1'b0;
          end
        end
        OP_SHR: begin
          lo_q  <= {opnd_b[0], opnd_a[DW-1:1]};
          hi_q  <= {1'b0, opnd_b[DW-1:1]};
          rdy_q <= 1'b1;
        end
        default: begin
          lo_q  <= '0;
          rdy_q <= 1'b0;
        end
      endcase
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (res_lo == '0 && res_hi == '0 && !ready && !err); // R1
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !ready); // R3

  AST_STEP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> res_lo[0] == 1'b0 && res_hi[0] == $past(res_lo[DW-1])); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> cnt_q == $past(cnt_q) - CW'(1)); // R4

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start && op_code == OP_SHL && opnd_b == '0)
      |=> ready && res_lo == $past(opnd_a) && res_hi == '0); // R5

  AST_RIGHT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start && op_code == OP_SHR)
      |=> ready && res_lo == {$past(opnd_b[0]), $past(opnd_a[DW-1:1])}
          && res_hi == {1'b0, $past(opnd_b[DW-1:1])}); // R7

  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start && op_code != OP_SHL && op_code != OP_SHR)
      |=> !ready && res_lo == '0 && res_hi == $past(res_hi)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(res_lo) && $stable(res_hi) && $stable(ready)); // R10
endmodule

// File: tb/seq_shift_unit_tb_top.sv
module seq_shift_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [3:0] a = '0, b = '0;
  logic [2:0] op = '0;
  logic       start = 1'b0;
  logic [3:0] lo, hi;
  logic       rdy, er;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  seq_shift_unit dut_i (
    .rst_n(rst_n), .clk(clk), .opnd_a(a), .opnd_b(b), .op_code(op),
    .start(start), .res_lo(lo), .res_hi(hi), .ready(rdy), .err(er)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic dispatch(input logic [2:0] o, input logic [3:0] va, input logic [3:0] vb);
    @(negedge clk);
    op = o; a = va; b = vb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rdy && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 lo", lo, 0); chk("R1 hi", hi, 0);
    chk("R1 ready", rdy, 0); chk("R1 err", er, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_shl(input logic [3:0] va, input logic [3:0] vb);
    int n;
    logic [7:0] exp;
    exp = 8'({4'b0, va} << vb);
    dispatch(3'b001, va, vb);
    if (vb != 0) chk("R3 ready low at capture", rdy, 0);
    wait_ready(n);
    chk(vb == 0 ? "R5 cycles" : "R3 cycles", n, vb);
    chk(vb >= 8 ? "R6 result" : "R2 result", {hi, lo}, exp);
    chk("R9 err", er, 0);
  endtask

  task automatic t_busy_ignore();
    int n;
    dispatch(3'b001, 4'b1011, 4'd11);
    repeat (4) begin
      op = 3'b010; a = 4'hF; b = 4'hF; start = 1'b1;
      @(negedge clk);
      chk("R3 ready low while busy", rdy, 0);
    end
    start = 1'b0;
    wait_ready(n);
    chk("R4 cycles", n + 4, 11);
    chk("R4 result", {hi, lo}, 8'h00);
    dispatch(3'b001, 4'b1011, 4'd3);
    repeat (2) begin
      op = 3'b000; a = 4'h0; b = 4'h0; start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    wait_ready(n);
    chk("R4 result", {hi, lo}, 8'h58);
  endtask

  task automatic t_shr(input logic [3:0] va, input logic [3:0] vb);
    dispatch(3'b010, va, vb);
    chk("R7 ready", rdy, 1);
    chk("R7 lo", lo, {vb[0], va[3:1]});
    chk("R7 hi", hi, {1'b0, vb[3:1]});
    chk("R9 err", er, 0);
  endtask

  task automatic t_bad(input logic [2:0] o);
    logic [3:0] h;
    t_shr(4'h6, 4'hB);
    h = hi;
    dispatch(o, 4'hF, 4'h2);
    chk("R8 ready", rdy, 0);
    chk("R8 lo", lo, 0);
    chk("R8 hi kept", hi, h);
    chk("R8 err", er, 0);
  endtask

  task automatic t_hold();
    logic [3:0] l0, h0;
    logic r0;
    t_shl(4'h9, 4'd2);
    l0 = lo; h0 = hi; r0 = rdy;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      a = 4'(i * 5); b = 4'(i + 1); op = 3'(i);
      chk("R10 lo", lo, l0); chk("R10 hi", hi, h0); chk("R10 ready", rdy, r0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_shl(4'h3, 4'd0);
    t_shl(4'hA, 4'd1);
    t_shl(4'hD, 4'd3);
    t_shl(4'hF, 4'd4);
    t_shl(4'h9, 4'd7);
    t_shl(4'hF, 4'd8);
    t_shl(4'hC, 4'd15);
    t_busy_ignore();
    t_shr(4'h6, 4'hB);
    t_shr(4'h1, 4'h4);
    t_bad(3'b000);
    t_bad(3'b111);
    t_bad(3'b101);
    t_hold();
    t_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule